// File: doc/BRIEF.md
# Delay-slot fetch sequencer

This block holds the program counter of an in-order fetch stage and applies branch delay slots that software can see. Each cycle it issues one 32-bit instruction address. A decode stage sits one cycle behind fetch and returns branch information for the instruction fetched in the cycle before. That information is a branch flag, a likely flag, a comparison code, two register values and a target. The sequencer does not flush. It keeps fetching the N sequential instructions after the branch, where N is the `N_SLOTS` parameter (1 or 2). It then moves to the target in the next cycle if the branch resolved taken, or keeps going sequentially if it did not. No cycle is lost in either case.

For a likely branch that resolves not taken, the delay-slot fetch cycles still occur, but the block drives their valid bit low so that the rest of the pipeline treats them as bubbles. Each fetched address also carries a slot index, so downstream logic knows which delay slot it belongs to. The comparison uses the two register values directly and involves no condition flags. A branch that decode reports for an instruction sitting in a delay slot is an illegal sequence. The block flags it on an error output and does not act on it.

Top module: `dsf_fetch_seq`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `fetch_pc_o` equals `RESET_PC` (default 0x800), `fetch_valid_o` is 1, `slot_idx_o` is 0 and `seq_err_o` is 0.
- R2: When the previous fetch was not the last delay slot of a taken branch, `fetch_pc_o` is the previous fetch address plus 4.
- R3: `br_cmp_i` selects the condition: 0 = rs equal rt, 1 = rs not equal rt, 2 = rs below zero, 3 = rs at or above zero, 4 = rs at or below zero, 5 = rs above zero, where rs is signed. Codes 6 and 7 never take.
- R4: For an ordinary branch (`br_likely_i` = 0), both delay-slot fetches carry `fetch_valid_o` = 1 whether the branch is taken or not.
- R5: For a taken branch fetched in cycle c, the target is fetched in cycle c+N+1, directly after the last slot, with no idle cycle.
- R6: For a not-taken branch at address B, the fetch in cycle c+N+1 is B+4(N+1).
- R7: For a taken likely branch, the delay-slot fetches carry `fetch_valid_o` = 1.
- R8: For a not-taken likely branch, the delay-slot fetch cycles still take place at B+4..B+4N, but with `fetch_valid_o` = 0.
- R9: `slot_idx_o` is k (1..N) during the fetch of the k-th delay slot of an accepted branch, and 0 otherwise.
- R10: Decode inputs refer to the instruction fetched in the previous cycle. If `br_valid_i` is asserted for an instruction that was a delay slot, `seq_err_o` is 1 in that cycle, and the branch has no effect on the fetch addresses or on the slot indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| br_valid_i | input | 1 | The instruction in decode is a branch |
| br_likely_i | input | 1 | The branch annuls its slots when not taken |
| br_cmp_i | input | 3 | Condition code (see R3) |
| br_rs_i | input | DATA_W | First register operand |
| br_rt_i | input | DATA_W | Second register operand |
| br_tgt_i | input | ADDR_W | Branch target address |
| fetch_pc_o | output | ADDR_W | Address fetched this cycle |
| fetch_valid_o | output | 1 | The fetched instruction is to be executed |
| slot_idx_o | output | $clog2(N_SLOTS+1) | Delay-slot number of this fetch, 0 if none |
| seq_err_o | output | 1 | Branch decoded inside a delay slot |

## Verification
A wrong slot counter changes the address stream within N+1 cycles of the branch. It shows up as a target fetched one cycle early or late, or as a slot number that skips or stalls. A wrongly latched likely or taken flag shows up as annul bits set on the wrong slot fetches. A stale record of the decode-side slot either raises a false sequence error or lets a slot branch redirect fetch, and either one is visible in the committed stream a few cycles later. The bench replays taken, not-taken and likely branches for every condition code, plus a branch placed in a slot. For each case it compares the committed address stream, the slot numbers and the cycle in which the target arrives against values it computes on its own.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  typedef enum logic [2:0] {
    CMP_EQ  = 3'd0,
    CMP_NE  = 3'd1,
    CMP_LTZ = 3'd2,
    CMP_GEZ = 3'd3,
    CMP_LEZ = 3'd4,
    CMP_GTZ = 3'd5
  } cmp_e;

  localparam int unsigned INSTR_BYTES = 4;
endpackage

// File: rtl/dsf_cond_eval.sv
module dsf_cond_eval #(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        cmp_i,
  input  logic [DATA_W-1:0] rs_i,
  input  logic [DATA_W-1:0] rt_i,
  output logic              taken_o
);
  import dsf_pkg::*;

  cmp_e cmp;
  logic rs_neg, rs_zero, ops_eq;

  assign cmp     = cmp_e'(cmp_i);
  assign rs_neg  = rs_i[DATA_W-1];
  assign rs_zero = (rs_i == '0);
  assign ops_eq  = (rs_i == rt_i);

  always_comb begin
    unique case (cmp)
      CMP_EQ:  taken_o = ops_eq;
      CMP_NE:  taken_o = !ops_eq;
      CMP_LTZ: taken_o = rs_neg;
      CMP_GEZ: taken_o = !rs_neg;
      CMP_LEZ: taken_o = rs_neg || rs_zero;
      CMP_GTZ: taken_o = !rs_neg && !rs_zero;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dsf_slot_ctrl.sv
module dsf_slot_ctrl #(
  parameter int ADDR_W  = 32,
  parameter int N_SLOTS = 2,
  localparam int SC_W   = $clog2(N_SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              br_valid_i,
  input  logic              br_likely_i,
  input  logic              br_taken_i,
  input  logic [ADDR_W-1:0] br_tgt_i,
  output logic [SC_W-1:0]   slot_idx_o,
  output logic              fetch_valid_o,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_tgt_o,
  output logic              seq_err_o
);
  localparam logic [SC_W-1:0] LAST  = SC_W'(N_SLOTS);
  localparam logic [SC_W-1:0] FIRST = SC_W'(1);

  logic [SC_W-1:0]   slot_cnt_q, dec_slot_q, slot_cur, slot_nxt;
  logic [ADDR_W-1:0] tgt_q, tgt_cur;
  logic              take_q, annul_q, take_cur, annul_cur;
  logic              accept, slot_last;

  // a branch is legal only if the instruction in decode was not a slot
  assign accept    = br_valid_i && (dec_slot_q == '0);
  assign seq_err_o = br_valid_i && (dec_slot_q != '0);

  // accepted branch: the fetch in flight right now is slot 1
  assign slot_cur  = accept ? FIRST : slot_cnt_q;
  assign take_cur  = accept ? br_taken_i : take_q;
  assign tgt_cur   = accept ? br_tgt_i : tgt_q;
  assign annul_cur = accept ? (br_likely_i && !br_taken_i) : annul_q;
  assign slot_last = (slot_cur == LAST);

  always_comb begin
    if (slot_last || slot_cur == '0) slot_nxt = '0;
    else                             slot_nxt = slot_cur + FIRST;
  end

  assign slot_idx_o     = slot_cur;
  assign fetch_valid_o  = (slot_cur == '0) || !annul_cur;
  assign redirect_o     = slot_last && take_cur;
  assign redirect_tgt_o = tgt_cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_cnt_q <= '0;
      dec_slot_q <= '0;
      tgt_q      <= '0;
      take_q     <= 1'b0;
      annul_q    <= 1'b0;
    end else begin
      slot_cnt_q <= slot_nxt;
      dec_slot_q <= slot_cur;
      if (accept) begin
        tgt_q   <= br_tgt_i;
        take_q  <= br_taken_i;
        annul_q <= br_likely_i && !br_taken_i;
      end
    end
  end
endmodule

// File: rtl/dsf_pc_gen.sv
module dsf_pc_gen #(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_0800
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              redirect_i,
  input  logic [ADDR_W-1:0] redirect_tgt_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(dsf_pkg::INSTR_BYTES);

  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pc_q <= RESET_PC;
    else if (redirect_i) pc_q <= redirect_tgt_i;
    else                 pc_q <= pc_q + STEP;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/dsf_fetch_seq.sv
module dsf_fetch_seq #(
  parameter int                ADDR_W   = 32,
  parameter int                DATA_W   = 32,
  parameter int                N_SLOTS  = 2,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_0800,
  localparam int               SC_W     = $clog2(N_SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              br_valid_i,
  input  logic              br_likely_i,
  input  logic [2:0]        br_cmp_i,
  input  logic [DATA_W-1:0] br_rs_i,
  input  logic [DATA_W-1:0] br_rt_i,
  input  logic [ADDR_W-1:0] br_tgt_i,
  output logic [ADDR_W-1:0] fetch_pc_o,
  output logic              fetch_valid_o,
  output logic [SC_W-1:0]   slot_idx_o,
  output logic              seq_err_o
);
  logic              br_taken;
  logic              redirect;
  logic [ADDR_W-1:0] redirect_tgt;

  dsf_cond_eval #(.DATA_W(DATA_W)) u_cond (
    .cmp_i   (br_cmp_i),
    .rs_i    (br_rs_i),
    .rt_i    (br_rt_i),
    .taken_o (br_taken)
  );

  dsf_slot_ctrl #(.ADDR_W(ADDR_W), .N_SLOTS(N_SLOTS)) u_slot (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .br_valid_i     (br_valid_i),
    .br_likely_i    (br_likely_i),
    .br_taken_i     (br_taken),
    .br_tgt_i       (br_tgt_i),
    .slot_idx_o     (slot_idx_o),
    .fetch_valid_o  (fetch_valid_o),
    .redirect_o     (redirect),
    .redirect_tgt_o (redirect_tgt),
    .seq_err_o      (seq_err_o)
  );

  dsf_pc_gen #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .redirect_i     (redirect),
    .redirect_tgt_i (redirect_tgt),
    .pc_o           (fetch_pc_o)
  );
endmodule

// File: rtl/dsf_fetch_seq_chk.sv
module dsf_fetch_seq_chk #(
  parameter int ADDR_W  = 32,
  parameter int N_SLOTS = 2,
  parameter int SC_W    = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] fetch_pc_o,
  input logic              fetch_valid_o,
  input logic [SC_W-1:0]   slot_idx_o,
  input logic              seq_err_o
);
  localparam logic [SC_W-1:0]   LAST = SC_W'(N_SLOTS);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  // R2
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_idx_o != LAST) |=> (fetch_pc_o == $past(fetch_pc_o) + STEP));

  // R9
  slot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_idx_o <= LAST);

  // R9
  slot_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_idx_o != '0 && slot_idx_o != LAST) |=> (slot_idx_o == $past(slot_idx_o) + 1'b1));

  // R8
  kill_only_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_o |-> (slot_idx_o != '0));

  // R8
  kill_uniform_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_idx_o > 1) |-> (fetch_valid_o == $past(fetch_valid_o)));

  // R10
  err_no_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o |-> (slot_idx_o != 1));
endmodule

bind dsf_fetch_seq dsf_fetch_seq_chk #(
  .ADDR_W(ADDR_W), .N_SLOTS(N_SLOTS), .SC_W(SC_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fetch_pc_o    (fetch_pc_o),
  .fetch_valid_o (fetch_valid_o),
  .slot_idx_o    (slot_idx_o),
  .seq_err_o     (seq_err_o)
);

// File: tb/tb_dsf_fetch_seq.sv
module tb_dsf_fetch_seq;
  localparam int NC = 10;
  localparam logic [31:0] BR_PC  = 32'h808;
  localparam logic [31:0] BAD_PC = 32'h80c;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        br_valid_i = 1'b0, br_likely_i = 1'b0;
  logic [2:0]  br_cmp_i = '0;
  logic [31:0] br_rs_i = '0, br_rt_i = '0, br_tgt_i = '0;
  logic [31:0] fetch_pc_o;
  logic        fetch_valid_o;
  logic [1:0]  slot_idx_o;
  logic        seq_err_o;

  int checks = 0, errors = 0;
  logic [31:0] fp [NC];
  logic        fv [NC];
  logic [1:0]  fs [NC];
  logic        fe [NC];

  always #4 clk_i = ~clk_i;

  dsf_fetch_seq dut (
    .clk_i, .rst_ni, .br_valid_i, .br_likely_i, .br_cmp_i, .br_rs_i,
    .br_rt_i, .br_tgt_i, .fetch_pc_o, .fetch_valid_o, .slot_idx_o, .seq_err_o
  );

  task automatic chk(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  // R3 reference
  function automatic logic cond_ref(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
    case (c)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd2: return $signed(a) < 0;
      3'd3: return $signed(a) >= 0;
      3'd4: return $signed(a) <= 0;
      3'd5: return $signed(a) > 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    br_valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    #1;
    // R1 in reset
    chk("R1 reset pc", fetch_pc_o == 32'h800, fetch_pc_o, 32'h800);
    chk("R1 reset valid/slot/err", fetch_valid_o && slot_idx_o == 0 && !seq_err_o,
        {fetch_valid_o, slot_idx_o, seq_err_o}, 32'h8);
    rst_ni = 1'b1;
  endtask

  task automatic run_case(input string nm, input logic [2:0] cmp, input logic lk,
                          input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] tgt, input logic bad);
    logic        tk, annul, ok;
    logic [31:0] dec_pc, exp_pc;
    logic        dec_v;
    logic [31:0] exp_l [NC];
    logic [31:0] act_l [NC];
    int          ne, na;
    tk = cond_ref(cmp, a, b);
    annul = lk && !tk;
    do_reset();
    dec_v = 1'b0;
    dec_pc = '0;
    for (int c = 0; c < NC; c++) begin
      if (c > 0) @(negedge clk_i);
      br_valid_i = 1'b0;
      if (dec_v && dec_pc == BR_PC) begin
        br_valid_i = 1'b1; br_likely_i = lk; br_cmp_i = cmp;
        br_rs_i = a; br_rt_i = b; br_tgt_i = tgt;
      end else if (bad && dec_v && dec_pc == BAD_PC) begin
        br_valid_i = 1'b1; br_likely_i = 1'b0; br_cmp_i = 3'd0;
        br_rs_i = '0; br_rt_i = '0; br_tgt_i = 32'hf00;
      end
      #1;
      fp[c] = fetch_pc_o; fv[c] = fetch_valid_o; fs[c] = slot_idx_o; fe[c] = seq_err_o;
      dec_pc = fetch_pc_o; dec_v = fetch_valid_o;
    end
    br_valid_i = 1'b0;
    // R1 first cycle after reset
    chk({"R1 first fetch ", nm}, fp[0] == 32'h800 && fv[0], fp[0], 32'h800);
    // R9 slot numbering
    ok = 1'b1;
    for (int c = 0; c < NC; c++)
      if (fs[c] != ((c == 3) ? 2'd1 : (c == 4) ? 2'd2 : 2'd0)) ok = 1'b0;
    chk({"R9 slot idx ", nm}, ok, {fs[3], fs[4]}, 32'h6);
    // R5 / R6 no-bubble redirect timing
    exp_pc = tk ? tgt : 32'h814;
    chk({tk ? "R5 target cycle " : "R6 fallthrough cycle ", nm}, fp[5] == exp_pc, fp[5], exp_pc);
    // R4 / R7 / R8 slot validity
    if (annul)
      chk({"R8 annulled slots ", nm}, !fv[3] && !fv[4] && fp[3] == 32'h80c && fp[4] == 32'h810,
          {fv[3], fv[4]}, 32'h0);
    else
      chk({lk ? "R7 likely slots " : "R4 slots executed ", nm}, fv[3] && fv[4], {fv[3], fv[4]}, 32'h3);
    // R10 error flag
    ok = 1'b1;
    for (int c = 0; c < NC; c++) if (fe[c] != (bad && c == 4)) ok = 1'b0;
    chk({"R10 seq err ", nm}, ok, fe[4], bad);
    // committed stream vs reference (R2 R4 R5 R6 R8 R10)
    ne = 0;
    exp_l[ne++] = 32'h800; exp_l[ne++] = 32'h804; exp_l[ne++] = 32'h808;
    if (!annul) begin exp_l[ne++] = 32'h80c; exp_l[ne++] = 32'h810; end
    for (int k = 0; k < NC - 5; k++) exp_l[ne++] = exp_pc + 32'(4 * k);
    na = 0;
    for (int c = 0; c < NC; c++) if (fv[c]) act_l[na++] = fp[c];
    ok = (na == ne);
    exp_pc = '0; dec_pc = '0;
    for (int k = 0; k < NC; k++)
      if (ok && k < ne && act_l[k] != exp_l[k]) begin ok = 1'b0; exp_pc = exp_l[k]; dec_pc = act_l[k]; end
    chk({"R2 committed stream ", nm}, ok, ok ? 32'(na) : dec_pc, ok ? 32'(ne) : exp_pc);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    run_case("eq taken",      3'd0, 1'b0, 32'd5, 32'd5, 32'h900, 1'b0);
    run_case("eq not taken",  3'd0, 1'b0, 32'd5, 32'd6, 32'h900, 1'b0);
    run_case("ne taken",      3'd1, 1'b0, 32'd1, 32'd2, 32'ha00, 1'b0);
    run_case("ltz taken R3",  3'd2, 1'b0, 32'hffff_ffff, 32'd0, 32'h900, 1'b0);
    run_case("gez not R3",    3'd3, 1'b0, 32'h8000_0000, 32'd0, 32'h900, 1'b0);
    run_case("lez zero R3",   3'd4, 1'b0, 32'd0, 32'd9, 32'h940, 1'b0);
    run_case("gtz zero R3",   3'd5, 1'b0, 32'd0, 32'd0, 32'h900, 1'b0);
    run_case("gtz taken R3",  3'd5, 1'b0, 32'd7, 32'd0, 32'h900, 1'b0);
    run_case("code7 R3",      3'd7, 1'b0, 32'd0, 32'd0, 32'h900, 1'b0);
    run_case("likely taken",  3'd0, 1'b1, 32'd3, 32'd3, 32'hc00, 1'b0);
    run_case("likely not",    3'd1, 1'b1, 32'd3, 32'd3, 32'hc00, 1'b0);
    run_case("slot branch",   3'd0, 1'b0, 32'd4, 32'd4, 32'h900, 1'b1);
    run_case("slot br nt",    3'd1, 1'b0, 32'd4, 32'd4, 32'h900, 1'b1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule